// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Latched Flag Threshold

This block is a first-in first-out buffer that crosses data between two unrelated clock domains. A producer writes 36-bit words on its own clock and a consumer reads them on another. Each side sees only flags that are registered in its own domain. The write side gets a not-full flag and a not-almost-full flag. The read side gets a not-empty flag and a not-almost-empty flag. All four flags are active low, so a low level means the condition holds.

Each pointer is seven bits wide: six address bits plus one wrap bit. A pointer travels to the other domain as Gray code through a two-stage synchronizer. The far side therefore always sees a pointer that is old but valid, and its flags err on the safe side.

The almost-full and almost-empty flags share one threshold X. Each side captures X from a two-bit select input while it is held in reset, and freezes it once it leaves reset. Writing to the select input later has no effect.

Reset is asynchronous and active low. Each domain leaves reset on its own clock. The write side reports "not full" only on the second write-clock edge after reset is released.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst_n` is low, `full_n` is 0, `afull_n` is 1, `empty_n` is 0 and `aempty_n` is 0.
- R2: After `rst_n` rises, `full_n` stays 0 after the first rising edge of `wr_clk` and reads 1 after the second. `empty_n` stays 0 while no word has been written.
- R3: The threshold is X = 4 × (`thr_sel` + 1), giving 00→4, 01→8, 10→12 and 11→16. It is taken from the value `thr_sel` holds when reset is released. Changing `thr_sel` afterwards does not alter either flag threshold.
- R4: The buffer holds 64 words. If 64 writes are accepted with no reads, `full_n` goes to 0 on the edge of the 64th write.
- R5: A write is accepted only on a `wr_clk` edge where `wr_en` is 1 and `full_n` is 1. A write attempted while `full_n` is 0 stores nothing and does not move the write pointer.
- R6: A read is accepted only on a `rd_clk` edge where `rd_en` is 1 and `empty_n` is 1. A read attempted while `empty_n` is 0 leaves `rd_data` unchanged and does not move the read pointer.
- R7: `afull_n` is 0 when the free count seen by the write side is at most X. While the read side is idle, this holds exactly, and the flag takes its new value on the write edge.
- R8: `aempty_n` is 0 when the word count seen by the read side is at most X. While the write side is idle, this holds exactly, and the flag takes its new value on the read edge.
- R9: `rd_data` is a register. It takes the next word, in write order, on the `rd_clk` edge that performs the read.
- R10: The flags are conservative. `full_n` = 1 implies fewer than 64 words are stored, and `empty_n` = 1 implies at least one word is stored. Once the opposite side goes idle, each flag reaches its exact value within four edges of its own clock. The pointers that cross domains change by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| thr_sel | input | 2 | Threshold select, captured at reset release |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when free space is at most X (write domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read word |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when word count is at most X (read domain) |

## Verification
A corrupted local pointer shows up on the very next edge of its own clock. It moves `full_n` or `afull_n` off the count the bench expects, or it makes `rd_data` return the wrong word, or the right word out of order.

A fault in the Gray crossing or the synchronizers shows up differently. Either the opposite flag never settles within a few edges after traffic stops, or the conservative bounds break during mixed traffic.

A wrongly captured threshold moves the edge where an almost flag changes. The bench detects this while filling or draining the buffer one word at a time, for each of the four select codes.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // threshold X = step * (code + 1)
  function automatic logic [31:0] thr_of(input logic [1:0] sel, input int unsigned step);
    return (32'(sel) + 32'd1) * 32'(step);
  endfunction

endpackage

// File: rtl/xclk_fifo_mem.sv
`timescale 1ns/1ps
module xclk_fifo_mem #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/xclk_fifo_gsync.sv
`timescale 1ns/1ps
module xclk_fifo_gsync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/xclk_fifo_wside.sv
`timescale 1ns/1ps
module xclk_fifo_wside
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned THR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        thr_sel,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   far_gray,
  output logic [ADDR_W:0]   own_gray,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              full_n,
  output logic              afull_n
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic          live_q;
  logic [PW-1:0] thr_q;
  logic [PW-1:0] ptr_q, ptr_d, gray_q, gray_d;
  logic          full_q, full_d, afull_q, afull_d;
  logic [PW-1:0] far_bin, used, free;
  logic          do_wr;

  // next state
  always_comb begin
    do_wr   = wr_en & full_q;
    ptr_d   = ptr_q + PW'(do_wr);
    gray_d  = PW'(bin_to_gray(32'(ptr_d)));
    far_bin = PW'(gray_to_bin(32'(far_gray)));
    used    = ptr_d - far_bin;
    free    = PW'(DEPTH) - used;
    full_d  = live_q && (used != PW'(DEPTH));
    afull_d = !live_q || (free > thr_q);
  end

  // one-stage release; the flag register acts as the second stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // threshold follows the select while in reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!live_q) thr_q <= PW'(thr_of(thr_sel, THR_STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      gray_q  <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b1;
    end else begin
      if (do_wr) begin
        ptr_q  <= ptr_d;
        gray_q <= gray_d;
      end
      full_q  <= full_d;
      afull_q <= afull_d;
    end
  end

  assign own_gray = gray_q;
  assign waddr    = ptr_q[ADDR_W-1:0];
  assign we       = do_wr;
  assign full_n   = full_q;
  assign afull_n  = afull_q;
endmodule

// File: rtl/xclk_fifo_rside.sv
`timescale 1ns/1ps
module xclk_fifo_rside
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned THR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        thr_sel,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   far_gray,
  output logic [ADDR_W:0]   own_gray,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              live_q;
  logic [PW-1:0]     thr_q;
  logic [PW-1:0]     ptr_q, ptr_d, gray_q, gray_d;
  logic              empty_q, empty_d, aempty_q, aempty_d;
  logic [PW-1:0]     far_bin, avail;
  logic              do_rd;
  logic [DATA_W-1:0] data_q;

  // next state
  always_comb begin
    do_rd    = rd_en & empty_q;
    ptr_d    = ptr_q + PW'(do_rd);
    gray_d   = PW'(bin_to_gray(32'(ptr_d)));
    far_bin  = PW'(gray_to_bin(32'(far_gray)));
    avail    = far_bin - ptr_d;
    empty_d  = live_q && (avail != '0);
    aempty_d = live_q && (avail > thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!live_q) thr_q <= PW'(thr_of(thr_sel, THR_STEP));
  end

  always_ff @(posedge clk) begin
    if (do_rd) data_q <= mem_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      gray_q   <= '0;
      empty_q  <= 1'b0;
      aempty_q <= 1'b0;
    end else begin
      if (do_rd) begin
        ptr_q  <= ptr_d;
        gray_q <= gray_d;
      end
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
    end
  end

  assign own_gray = gray_q;
  assign raddr    = ptr_q[ADDR_W-1:0];
  assign rd_data  = data_q;
  assign empty_n  = empty_q;
  assign aempty_n = aempty_q;
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned THR_STEP = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [1:0]        thr_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_r, rd_gray_w;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we;
  logic [DATA_W-1:0] mem_word;

  xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_word)
  );

  xclk_fifo_gsync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .din(rd_gray), .dout(rd_gray_w)
  );

  xclk_fifo_gsync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .din(wr_gray), .dout(wr_gray_r)
  );

  xclk_fifo_wside #(.ADDR_W(ADDR_W), .THR_STEP(THR_STEP)) u_wside (
    .clk(wr_clk), .rst_n(rst_n), .thr_sel(thr_sel), .wr_en(wr_en),
    .far_gray(rd_gray_w), .own_gray(wr_gray), .waddr(waddr), .we(we),
    .full_n(full_n), .afull_n(afull_n)
  );

  xclk_fifo_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_STEP(THR_STEP)) u_rside (
    .clk(rd_clk), .rst_n(rst_n), .thr_sel(thr_sel), .rd_en(rd_en),
    .far_gray(wr_gray_r), .own_gray(rd_gray), .raddr(raddr),
    .mem_word(mem_word), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              full_n,
  input logic              afull_n,
  input logic              empty_n,
  input logic              aempty_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wr_gray,
  input logic [ADDR_W:0]   rd_gray,
  input logic [ADDR_W:0]   rd_gray_w
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] seen_used;
  assign seen_used = PW'(gray_to_bin(32'(wr_gray))) - PW'(gray_to_bin(32'(rd_gray_w)));

  // R1
  reset_wflags_chk: assert property (@(posedge wr_clk) !rst_n |-> (!full_n && afull_n));

  // R1
  reset_rflags_chk: assert property (@(posedge rd_clk) !rst_n |-> (!empty_n && !aempty_n));

  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_gray));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> ($stable(rd_data) && $stable(rd_gray)));

  // R4
  occupancy_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    seen_used <= PW'(DEPTH));

  // R10
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R10
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .rd_data(rd_data), .wr_gray(wr_gray), .rd_gray(rd_gray), .rd_gray_w(rd_gray_w)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/1ps
module test_xclk_fifo;
  localparam int DEPTH = 64;

  logic        wr_clk, rd_clk, rst_n;
  logic [1:0]  thr_sel;
  logic        wr_en, rd_en;
  logic [35:0] wr_data, rd_data;
  logic        full_n, afull_n, empty_n, aempty_n;

  int checks, failures;
  int wcnt, rcnt, wtot, rtot;
  bit wdone;

  xclk_fifo i_xclk_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .thr_sel(thr_sel),
    .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
    .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  initial begin wr_clk = 0; forever #10 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; forever #17 rd_clk = ~rd_clk; end

  function automatic logic [35:0] word_of(int c, int k);
    return {4'(c), 16'(k), 16'(k * 40503 + c)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(int c);
    #3 rst_n = 0;
    thr_sel = 2'(c);
    repeat (8) @(negedge wr_clk);
    chk("R1 full_n", 64'(full_n), 64'd0);
    chk("R1 afull_n", 64'(afull_n), 64'd1);
    chk("R1 empty_n", 64'(empty_n), 64'd0);
    chk("R1 aempty_n", 64'(aempty_n), 64'd0);
    rst_n = 1;
    @(negedge wr_clk);
    chk("R2 full_n after 1st edge", 64'(full_n), 64'd0);
    @(negedge wr_clk);
    chk("R2 full_n after 2nd edge", 64'(full_n), 64'd1);
    chk("R2 afull_n", 64'(afull_n), 64'd1);
    chk("R2 empty_n", 64'(empty_n), 64'd0);
    repeat (4) @(negedge wr_clk);
    thr_sel = ~2'(c);   // R3: must have no effect from now on
  endtask

  task automatic run_code(int c);
    int x;
    int unsigned seed_w, seed_r;
    x = 4 * (c + 1);
    do_reset(c);
    // fill, read side idle (R4 R5 R7 R3)
    wcnt = 0;
    for (int n = 1; n <= DEPTH + 2; n++) begin
      bit acc;
      @(negedge wr_clk);
      wr_en = 1; wr_data = (wcnt < DEPTH) ? word_of(c, wcnt + 1) : ~word_of(c, n);
      acc = (wcnt < DEPTH);
      @(negedge wr_clk);
      wr_en = 0;
      if (acc) wcnt++;
      chk("R4 R5 full_n fill", 64'(full_n), 64'(wcnt != DEPTH));
      chk("R7 R3 afull_n fill", 64'(afull_n), 64'((DEPTH - wcnt) > x));
    end
    repeat (6) @(negedge rd_clk);
    chk("R10 empty_n settles", 64'(empty_n), 64'd1);
    chk("R10 aempty_n settles", 64'(aempty_n), 64'd1);
    // drain, write side idle (R6 R8 R9 R3)
    rcnt = 0;
    for (int m = 1; m <= DEPTH + 2; m++) begin
      bit acc;
      @(negedge rd_clk);
      rd_en = 1;
      acc = (rcnt < DEPTH);
      @(negedge rd_clk);
      rd_en = 0;
      if (acc) rcnt++;
      if (acc) chk("R9 rd_data order", 64'(rd_data), 64'(word_of(c, rcnt)));
      else     chk("R6 rd_data held", 64'(rd_data), 64'(word_of(c, DEPTH)));
      chk("R6 empty_n drain", 64'(empty_n), 64'(rcnt != DEPTH));
      chk("R8 R3 aempty_n drain", 64'(aempty_n), 64'((DEPTH - rcnt) > x));
    end
    repeat (6) @(negedge wr_clk);
    chk("R10 full_n settles", 64'(full_n), 64'd1);
    chk("R10 afull_n settles", 64'(afull_n), 64'd1);
    // mixed traffic on both clocks (R9 R10)
    wtot = 0; rtot = 0; wdone = 0;
    seed_w = 32'd12345 + 32'(c); seed_r = 32'd999 + 32'(c * 7);
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          bit f, en;
          @(negedge wr_clk);
          f = full_n;
          if (f) chk("R10 full_n conservative", 64'((wtot - rtot) < DEPTH), 64'd1);
          seed_w = seed_w * 32'd1103515245 + 32'd12345;
          en = (seed_w[17:16] != 2'b00);
          wr_en = en; wr_data = word_of(c, wtot + 1);
          if (en && f) wtot++;
        end
        @(negedge wr_clk);
        wr_en = 0; wdone = 1;
      end
      begin
        bit pend;
        pend = 0;
        while (!(wdone && rtot == wtot)) begin
          bit e, en;
          @(negedge rd_clk);
          if (pend) chk("R9 rd_data mixed", 64'(rd_data), 64'(word_of(c, rtot)));
          e = empty_n;
          if (e) chk("R10 empty_n conservative", 64'((wtot - rtot) > 0), 64'd1);
          seed_r = seed_r * 32'd1664525 + 32'd1013904223;
          en = wdone ? 1'b1 : (seed_r[19:18] != 2'b00);
          rd_en = en;
          pend = en && e;
          if (pend) rtot++;
        end
        @(negedge rd_clk);
        if (pend) chk("R9 rd_data mixed", 64'(rd_data), 64'(word_of(c, rtot)));
        rd_en = 0;
      end
    join
    repeat (6) @(negedge rd_clk);
    chk("R10 empty_n after mixed", 64'(empty_n), 64'd0);
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1; thr_sel = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    for (int c = 0; c < 4; c++) run_code(c);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule